// File: doc/BRIEF.md
# NAND Flash Die Behavioural Model

This block is a synthesizable, scaled-down stand-in for one single-level-cell NAND flash die. It is meant for controller simulation and FPGA prototypes. A small array of pages, grouped into erase blocks, is held in registers, together with one page register. A controller drives a shared 8-bit bus. A command-latch input and an address-latch input classify each write strobe, and a read strobe pulls bytes out. Every strobe is a single-cycle enable sampled on the rising clock edge.

The model covers these operations:
- page read into the register, followed by serial output
- repositioning of the output column inside the loaded page
- program setup with a full register preload, and column repositioning inside a program without a preload
- program confirm, which merges the register into the array by AND
- block erase
- status read
- identification read

A per-page counter limits the number of confirmed programs between erases. A ready output drops for a fixed number of clocks after every read, program or erase confirm.

Top module: `nand_die_model`

## Requirements
- R1: A write strobe is taken as a command when only the command latch is high, as an address when only the address latch is high, and as data when both latches are low. With both latches high the strobe has no effect.
- R2: Command 60h, one row byte, then D0h sets every byte of every page in the addressed block to FFh. It also clears the program counts of those pages and the fail flag. Pages of other blocks keep their contents.
- R3: Command 80h, column low byte, column high byte, row byte, data bytes, then 10h writes the page. The new page is the old page ANDed with the page register.
- R4: Command 80h fills the whole page register with FFh. Command 85h followed by two column bytes moves the data-load column and leaves the register contents as they are.
- R5: A confirm on a page that already holds NOP_LIMIT confirmed programs since its last erase leaves the page unchanged and sets the fail flag. Any other confirm clears the fail flag.
- R6: Command 00h, three address bytes, then 30h loads the addressed page into the register. Output starts at the given column, advances one byte per read strobe, and wraps from the last column to column 0. The same wrap applies to data loading.
- R7: Command 05h, two column bytes, then E0h moves the output column inside the page already in the register and returns the output to page data.
- R8: After 70h the output shows status. Bit 7 is 1, bits 6 and 5 are the ready flag, bits 4 to 1 are 0 and bit 0 is the fail flag. The value is E0h when the block is idle and has no failure, and 80h while it is busy. A page read leaves the fail flag unchanged.
- R9: Ready is high after reset and goes low for exactly BUSY_CYCLES clocks after a 30h, 10h or D0h confirm. While ready is low, every command except 70h is ignored, and so is every address or data strobe.
- R10: Command 90h followed by one address byte selects the identification output. The first byte read is 2Ch and every later byte is DEV_CODE.
- R11: In the row byte, the low log2(PAGES) bits select the page and the next log2(BLOCKS) bits select the block. Only the low log2(COLS) bits of the column low byte are used. The column high byte and any higher row bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cle | input | 1 | Command latch qualifier |
| ale | input | 1 | Address latch qualifier |
| wr_stb | input | 1 | Single-cycle write strobe |
| rd_stb | input | 1 | Single-cycle read strobe |
| din | input | 8 | Bus byte from the controller |
| dout | output | 8 | Page data, status or identification byte |
| ready | output | 1 | High when no array operation is running |

## Verification
The bench builds the model with 4 blocks of 4 pages of 8 bytes, a partial-program limit of 3 and a busy time of 4 clocks. With an 8-byte page, both the output wrap and the data-load wrap show up within a few strobes. With a limit of 3, the fourth program of one page fails and the bench can see it. The short busy window makes it possible to send a command, an address and a status request while the block is still busy, and then to see in the status byte that the block is busy.

// File: rtl/nand_pkg.sv
package nand_pkg;

  typedef enum logic [2:0] {
    OP_IDLE, OP_READ, OP_PROG, OP_ERASE, OP_RCOL, OP_ID
  } op_e;

  typedef enum logic [1:0] {
    OUT_DATA, OUT_STATUS, OUT_ID
  } out_e;

  localparam logic [7:0] C_READ   = 8'h00;
  localparam logic [7:0] C_READGO = 8'h30;
  localparam logic [7:0] C_LOAD   = 8'h80;
  localparam logic [7:0] C_MOVEIN = 8'h85;
  localparam logic [7:0] C_PROGGO = 8'h10;
  localparam logic [7:0] C_ERASE  = 8'h60;
  localparam logic [7:0] C_ERASGO = 8'hD0;
  localparam logic [7:0] C_MOVOUT = 8'h05;
  localparam logic [7:0] C_MOVGO  = 8'hE0;
  localparam logic [7:0] C_STATUS = 8'h70;
  localparam logic [7:0] C_IDENT  = 8'h90;
  localparam logic [7:0] MAKER_ID = 8'h2C;

  // Status layout: bit7 not-protected, bits 6 and 5 ready, bit0 fail
  function automatic logic [7:0] status_byte(input logic rdy, input logic fail);
    return {1'b1, rdy, rdy, 4'b0000, fail};
  endfunction

  // Programming only pulls bits towards zero
  function automatic logic [7:0] merge_byte(input logic [7:0] old_b, input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

endpackage

// File: rtl/nand_bus_decode.sv
module nand_bus_decode (
  input  logic cle,
  input  logic ale,
  input  logic wr_stb,
  input  logic rd_stb,
  output logic cmd_wr,
  output logic adr_wr,
  output logic dat_wr,
  output logic dat_rd
);
  // Both qualifiers high selects nothing
  assign cmd_wr = wr_stb &  cle & ~ale;
  assign adr_wr = wr_stb & ~cle &  ale;
  assign dat_wr = wr_stb & ~cle & ~ale;
  assign dat_rd = rd_stb & ~cle & ~ale;
endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
  parameter int BUSY_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ready
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (start)      cnt_q <= CW'(BUSY_CYCLES);
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign ready = (cnt_q == '0);

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ready); // R9
endmodule

// File: rtl/nand_array.sv
module nand_array #(
  parameter int BLOCKS    = 8,
  parameter int PAGES     = 8,
  parameter int COLS      = 16,
  parameter int NOP_LIMIT = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(BLOCKS*PAGES)-1:0] row,
  output logic [COLS*8-1:0]             page_out,
  input  logic                          prog_go,
  input  logic [COLS*8-1:0]             prog_data,
  output logic                          prog_full,
  input  logic                          erase_go
);
  import nand_pkg::*;
  localparam int ROWS  = BLOCKS * PAGES;
  localparam int ROW_W = $clog2(ROWS);
  localparam int PG_W  = $clog2(PAGES);
  localparam int CNT_W = $clog2(NOP_LIMIT + 1);

  logic [COLS*8-1:0] pages_q [ROWS];
  logic [CNT_W-1:0]  nop_q   [ROWS];
  logic [COLS*8-1:0] merged;

  assign page_out  = pages_q[row];
  assign prog_full = (nop_q[row] == CNT_W'(NOP_LIMIT));

  for (genvar b = 0; b < COLS; b++) begin : g_merge
    assign merged[b*8 +: 8] = merge_byte(pages_q[row][b*8 +: 8], prog_data[b*8 +: 8]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) begin
        pages_q[r] <= '1;
        nop_q[r]   <= '0;
      end
    end else if (erase_go) begin
      for (int r = 0; r < ROWS; r++) begin
        if ((ROW_W'(r) >> PG_W) == (row >> PG_W)) begin
          pages_q[r] <= '1;
          nop_q[r]   <= '0;
        end
      end
    end else if (prog_go && !prog_full) begin
      pages_q[row] <= merged;
      nop_q[row]   <= nop_q[row] + 1'b1;
    end
  end

  AST_ERASE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |=> (page_out == '1)); // R2
  AST_PROG_AND_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_go && !prog_full) |=> (page_out == ($past(page_out) & $past(prog_data)))); // R3
  AST_FULL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_go && prog_full) |=> $stable(page_out)); // R5
endmodule

// File: rtl/nand_die_model.sv
module nand_die_model #(
  parameter int         BLOCKS      = 8,
  parameter int         PAGES       = 8,
  parameter int         COLS        = 16,
  parameter int         NOP_LIMIT   = 8,
  parameter int         BUSY_CYCLES = 20,
  parameter logic [7:0] DEV_CODE    = 8'hD5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       wr_stb,
  input  logic       rd_stb,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       ready
);
  import nand_pkg::*;
  localparam int ROW_W = $clog2(BLOCKS * PAGES);
  localparam int COL_W = $clog2(COLS);
  localparam int PW    = COLS * 8;

  logic cmd_wr, adr_wr, dat_wr, dat_rd;
  op_e  op_q;
  out_e out_q;
  logic [1:0]       acnt_q, need_q, base_q;
  logic [COL_W-1:0] col_q, ptr_q;
  logic [ROW_W-1:0] row_q;
  logic [PW-1:0]    preg_q, arr_page;
  logic id_q, fail_q, prog_full;

  // Named launch events
  logic addr_done, rd_go, prog_go, erase_go, preload_go;
  assign addr_done  = (acnt_q == need_q);
  assign rd_go      = cmd_wr && ready && din == C_READGO && op_q == OP_READ  && addr_done;
  assign prog_go    = cmd_wr && ready && din == C_PROGGO && op_q == OP_PROG  && addr_done;
  assign erase_go   = cmd_wr && ready && din == C_ERASGO && op_q == OP_ERASE && addr_done;
  assign preload_go = cmd_wr && ready && din == C_LOAD;

  nand_bus_decode u_dec (
    .cle(cle), .ale(ale), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .cmd_wr(cmd_wr), .adr_wr(adr_wr), .dat_wr(dat_wr), .dat_rd(dat_rd)
  );

  nand_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(rd_go || prog_go || erase_go), .ready(ready)
  );

  nand_array #(.BLOCKS(BLOCKS), .PAGES(PAGES), .COLS(COLS), .NOP_LIMIT(NOP_LIMIT)) u_arr (
    .clk(clk), .rst_n(rst_n), .row(row_q), .page_out(arr_page),
    .prog_go(prog_go), .prog_data(preg_q), .prog_full(prog_full), .erase_go(erase_go)
  );

  task automatic start_seq(input op_e op, input logic [1:0] need, input logic [1:0] base);
    op_q   <= op;
    acnt_q <= 2'd0;
    need_q <= need;
    base_q <= base;
  endtask

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q <= OP_IDLE; out_q <= OUT_DATA;
      acnt_q <= '0; need_q <= '0; base_q <= '0;
      col_q <= '0; ptr_q <= '0; row_q <= '0;
      preg_q <= '1; id_q <= 1'b0; fail_q <= 1'b0;
    end else if (cmd_wr) begin
      if (!ready) begin
        if (din == C_STATUS) out_q <= OUT_STATUS;
      end else begin
        case (din)
          C_READ:   start_seq(OP_READ, 2'd3, 2'd0);
          C_READGO: if (rd_go) begin
                      preg_q <= arr_page; ptr_q <= col_q; out_q <= OUT_DATA; op_q <= OP_IDLE;
                    end
          C_LOAD:   begin start_seq(OP_PROG, 2'd3, 2'd0); preg_q <= '1; end
          C_MOVEIN: if (op_q == OP_PROG) start_seq(OP_PROG, 2'd2, 2'd0);
          C_PROGGO: if (prog_go) begin fail_q <= prog_full; op_q <= OP_IDLE; end
          C_ERASE:  start_seq(OP_ERASE, 2'd1, 2'd2);
          C_ERASGO: if (erase_go) begin fail_q <= 1'b0; op_q <= OP_IDLE; end
          C_MOVOUT: start_seq(OP_RCOL, 2'd2, 2'd0);
          C_MOVGO:  if (op_q == OP_RCOL && addr_done) begin
                      ptr_q <= col_q; out_q <= OUT_DATA; op_q <= OP_IDLE;
                    end
          C_STATUS: out_q <= OUT_STATUS;
          C_IDENT:  start_seq(OP_ID, 2'd1, 2'd3);
          default:  ;
        endcase
      end
    end else if (adr_wr && ready && !addr_done) begin
      acnt_q <= acnt_q + 1'b1;
      case (acnt_q + base_q)
        2'd0: col_q <= din[COL_W-1:0];
        2'd1: if (op_q == OP_PROG) ptr_q <= col_q;
        2'd2: row_q <= din[ROW_W-1:0];
        default: ;
      endcase
      if (op_q == OP_ID) begin out_q <= OUT_ID; id_q <= 1'b0; end
    end else if (dat_wr && ready && op_q == OP_PROG) begin
      preg_q[{ptr_q, 3'b000} +: 8] <= din;
      ptr_q <= ptr_q + 1'b1;
    end else if (dat_rd && ready) begin
      if (out_q == OUT_DATA)    ptr_q <= ptr_q + 1'b1;
      else if (out_q == OUT_ID) id_q  <= 1'b1;
    end
  end

  always_comb begin
    case (out_q)
      OUT_STATUS: dout = status_byte(ready, fail_q);
      OUT_ID:     dout = id_q ? DEV_CODE : MAKER_ID;
      default:    dout = preg_q[{ptr_q, 3'b000} +: 8];
    endcase
  end

  AST_PRELOAD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    preload_go |=> (preg_q == '1)); // R4
  AST_BUSY_HOLDS_REG: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !rd_go) |=> $stable(preg_q)); // R9
  AST_STATUS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q == OUT_STATUS && !ready) |-> (dout[6:5] == 2'b00)); // R8
endmodule

// File: tb/sim_nand_die_model.sv
module sim_nand_die_model;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cle = 0, ale = 0, we = 0, re = 0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic ready;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  nand_die_model #(.BLOCKS(4), .PAGES(4), .COLS(8), .NOP_LIMIT(3),
                   .BUSY_CYCLES(4), .DEV_CODE(8'hD5)) u0 (
    .clk(clk), .rst_n(rst_n), .cle(cle), .ale(ale), .wr_stb(we), .rd_stb(re),
    .din(din), .dout(dout), .ready(ready)
  );

  localparam logic [2:0] K_CMD = 3'd0, K_ADR = 3'd1, K_DAT = 3'd2, K_RD = 3'd3,
                         K_WAIT = 3'd4, K_PEEK = 3'd5, K_BOTH = 3'd6;
  localparam int NV = 163;
  // entry = {kind, byte or expected value, requirement number}
  localparam logic [14:0] VEC [NV] = '{
    {K_CMD,8'h70,4'd0}, {K_PEEK,8'hE0,4'd8},                               // R8 idle
    {K_CMD,8'h90,4'd0}, {K_ADR,8'h00,4'd0},
    {K_RD,8'h2C,4'd10}, {K_RD,8'hD5,4'd10}, {K_RD,8'hD5,4'd10},             // R10
    {K_CMD,8'h00,4'd0}, {K_ADR,8'h00,4'd0}, {K_ADR,8'h00,4'd0}, {K_ADR,8'h05,4'd0},
    {K_CMD,8'h30,4'd0}, {K_WAIT,8'h00,4'd0}, {K_RD,8'hFF,4'd6},             // R6 fresh page
    {K_CMD,8'h80,4'd0}, {K_ADR,8'h00,4'd0}, {K_ADR,8'h00,4'd0}, {K_ADR,8'h01,4'd0},
    {K_DAT,8'h5A,4'd0}, {K_CMD,8'h10,4'd0}, {K_WAIT,8'h00,4'd0},
    {K_CMD,8'h80,4'd0}, {K_ADR,8'h07,4'd0}, {K_ADR,8'h00,4'd0}, {K_ADR,8'h05,4'd0},
    {K_DAT,8'h77,4'd0}, {K_DAT,8'h12,4'd0},
    {K_CMD,8'h85,4'd0}, {K_ADR,8'h03,4'd0}, {K_ADR,8'h00,4'd0}, {K_DAT,8'h34,4'd0},
    {K_CMD,8'h10,4'd0}, {K_WAIT,8'h00,4'd0}, {K_CMD,8'h70,4'd0}, {K_PEEK,8'hE0,4'd8},
    {K_CMD,8'h00,4'd0}, {K_ADR,8'h06,4'd0}, {K_ADR,8'h00,4'd0}, {K_ADR,8'h05,4'd0},
    {K_CMD,8'h30,4'd0}, {K_WAIT,8'h00,4'd0},
    {K_RD,8'hFF,4'd6}, {K_RD,8'h77,4'd6}, {K_RD,8'h12,4'd6}, {K_RD,8'hFF,4'd4}, // R6 wrap, R4
    {K_CMD,8'h05,4'd0}, {K_ADR,8'h03,4'd0}, {K_ADR,8'h00,4'd0}, {K_CMD,8'hE0,4'd0},
    {K_RD,8'h34,4'd7}, {K_RD,8'hFF,4'd7},                                   // R7
    {K_CMD,8'h80,4'd0}, {K_ADR,8'h00,4'd0}, {K_ADR,8'h00,4'd0}, {K_ADR,8'h05,4'd0},
    {K_DAT,8'hF0,4'd0}, {K_DAT,8'h0F,4'd0}, {K_CMD,8'h10,4'd0}, {K_WAIT,8'h00,4'd0},
    {K_CMD,8'h00,4'd0}, {K_ADR,8'h00,4'd0}, {K_ADR,8'h00,4'd0}, {K_ADR,8'h05,4'd0},
    {K_CMD,8'h30,4'd0}, {K_WAIT,8'h00,4'd0},
    {K_RD,8'h10,4'd3}, {K_RD,8'h0F,4'd3},                                   // R3 AND merge
    {K_CMD,8'h05,4'd0}, {K_ADR,8'h07,4'd0}, {K_ADR,8'h00,4'd0}, {K_CMD,8'hE0,4'd0},
    {K_RD,8'h77,4'd4},                                                      // R4 preload
    {K_CMD,8'h80,4'd0}, {K_ADR,8'h04,4'd0}, {K_ADR,8'h00,4'd0}, {K_ADR,8'h05,4'd0},
    {K_DAT,8'h00,4'd0}, {K_CMD,8'h10,4'd0}, {K_WAIT,8'h00,4'd0},
    {K_CMD,8'h70,4'd0}, {K_PEEK,8'hE0,4'd5},                               // R5 at limit
    {K_CMD,8'h80,4'd0}, {K_ADR,8'h05,4'd0}, {K_ADR,8'h00,4'd0}, {K_ADR,8'h05,4'd0},
    {K_DAT,8'h00,4'd0}, {K_CMD,8'h10,4'd0}, {K_WAIT,8'h00,4'd0},
    {K_CMD,8'h70,4'd0}, {K_PEEK,8'hE1,4'd5},                               // R5 over limit
    {K_CMD,8'h00,4'd0}, {K_ADR,8'h04,4'd0}, {K_ADR,8'h00,4'd0}, {K_ADR,8'h05,4'd0},
    {K_CMD,8'h30,4'd0}, {K_WAIT,8'h00,4'd0},
    {K_RD,8'h00,4'd5}, {K_RD,8'hFF,4'd5},
    {K_CMD,8'h70,4'd0}, {K_PEEK,8'hE1,4'd8},                               // R8 read keeps fail
    {K_CMD,8'h60,4'd0}, {K_ADR,8'h05,4'd0}, {K_CMD,8'hD0,4'd0}, {K_WAIT,8'h00,4'd0},
    {K_CMD,8'h70,4'd0}, {K_PEEK,8'hE0,4'd2},                               // R2
    {K_CMD,8'h00,4'd0}, {K_ADR,8'h00,4'd0}, {K_ADR,8'h00,4'd0}, {K_ADR,8'h05,4'd0},
    {K_CMD,8'h30,4'd0}, {K_WAIT,8'h00,4'd0}, {K_RD,8'hFF,4'd2}, {K_RD,8'hFF,4'd2},
    {K_CMD,8'h00,4'd0}, {K_ADR,8'h00,4'd0}, {K_ADR,8'h00,4'd0}, {K_ADR,8'h01,4'd0},
    {K_CMD,8'h30,4'd0}, {K_WAIT,8'h00,4'd0}, {K_RD,8'h5A,4'd2},             // R2 other block kept
    {K_CMD,8'h80,4'd0}, {K_ADR,8'h00,4'd0}, {K_ADR,8'h00,4'd0}, {K_ADR,8'h05,4'd0},
    {K_DAT,8'h55,4'd0}, {K_CMD,8'h10,4'd0}, {K_WAIT,8'h00,4'd0},
    {K_CMD,8'h70,4'd0}, {K_PEEK,8'hE0,4'd2},                               // R2 count cleared
    {K_CMD,8'h80,4'd0}, {K_ADR,8'h00,4'd0}, {K_ADR,8'h00,4'd0}, {K_ADR,8'h05,4'd0},
    {K_BOTH,8'h10,4'd0}, {K_DAT,8'hAA,4'd0}, {K_CMD,8'h10,4'd0}, {K_WAIT,8'h00,4'd0},
    {K_CMD,8'h00,4'd0}, {K_ADR,8'h00,4'd0}, {K_ADR,8'h00,4'd0}, {K_ADR,8'h05,4'd0},
    {K_CMD,8'h30,4'd0}, {K_WAIT,8'h00,4'd0}, {K_RD,8'h00,4'd1}, {K_RD,8'hFF,4'd1}, // R1
    {K_CMD,8'h00,4'd0}, {K_ADR,8'h00,4'd0}, {K_ADR,8'h00,4'd0}, {K_ADR,8'h05,4'd0},
    {K_CMD,8'h30,4'd0}, {K_CMD,8'h60,4'd0}, {K_ADR,8'h05,4'd0}, {K_CMD,8'h70,4'd0},
    {K_PEEK,8'h80,4'd9}, {K_WAIT,8'h00,4'd0}, {K_PEEK,8'hE0,4'd8},          // R9 busy status
    {K_CMD,8'hD0,4'd0}, {K_CMD,8'h05,4'd0}, {K_ADR,8'h00,4'd0}, {K_ADR,8'h00,4'd0},
    {K_CMD,8'hE0,4'd0}, {K_RD,8'h00,4'd9}                                   // R9 erase ignored
  };

  task automatic check(input bit ok, input int req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d: got %02h expected %02h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic strobe(input logic c, input logic a, input logic [7:0] b);
    cle = c; ale = a; din = b; we = 1'b1;
    @(negedge clk);
    we = 1'b0; cle = 1'b0; ale = 1'b0;
  endtask

  task automatic run_entry(input logic [14:0] e);
    logic [2:0] k;
    logic [7:0] v;
    k = e[14:12];
    v = e[11:4];
    case (k)
      K_CMD:  strobe(1'b1, 1'b0, v);
      K_ADR:  strobe(1'b0, 1'b1, v);
      K_DAT:  strobe(1'b0, 1'b0, v);
      K_BOTH: strobe(1'b1, 1'b1, v);
      K_WAIT: while (!ready) @(negedge clk);
      K_PEEK: check(dout == v, int'(e[3:0]), dout, v);
      K_RD: begin
        check(dout == v, int'(e[3:0]), dout, v);
        re = 1'b1;
        @(negedge clk);
        re = 1'b0;
      end
      default: ;
    endcase
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state: ready and an all-ones register (R9)
    check(ready == 1'b1, 9, {7'd0, ready}, 8'h01);
    check(dout == 8'hFF, 9, dout, 8'hFF);

    for (int i = 0; i < NV; i++) run_entry(VEC[i]);

    // R9: busy window length after a read confirm
    begin
      int low;
      strobe(1'b1, 1'b0, 8'h00);
      strobe(1'b0, 1'b1, 8'h00);
      strobe(1'b0, 1'b1, 8'h00);
      strobe(1'b0, 1'b1, 8'h02);
      strobe(1'b1, 1'b0, 8'h30);
      low = 0;
      while (!ready) begin
        low++;
        @(negedge clk);
      end
      check(low == 4, 9, 8'(low), 8'd4);
    end

    // R11: higher row bits ignored, row 16+5 addresses row 5
    strobe(1'b1, 1'b0, 8'h00);
    strobe(1'b0, 1'b1, 8'h08);
    strobe(1'b0, 1'b1, 8'h3F);
    strobe(1'b0, 1'b1, 8'h15);
    strobe(1'b1, 1'b0, 8'h30);
    while (!ready) @(negedge clk);
    check(dout == 8'h00, 11, dout, 8'h00); // column 8 folds to 0
    re = 1'b1; @(negedge clk); re = 1'b0;
    check(dout == 8'hFF, 11, dout, 8'hFF);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule